// File: doc/BRIEF.md
# Wired-AND Bus Frame Transmitter with Bitwise Arbitration

This block sends one message frame onto a multi-master serial line where any node can pull the line to the dominant level (0). Several nodes may begin a frame in the same bit period. While the identifier is on the line, each node reads every bit back. A node that drives a recessive 1 but reads a dominant 0 has met a higher-priority identifier. It releases the line at once and takes no further part in that frame. A numerically lower identifier therefore always wins, and it wins without losing any bits.

A frame consists of a dominant start bit, the identifier sent MSB first, a 4-bit length code, the data bytes, an acknowledge slot and a tail of recessive end bits. Every listener pulls the acknowledge slot dominant. If the slot reads back recessive, the attempt counts as failed: a saturating error counter is bumped and the frame is sent again. After a run of failed attempts the transmitter stops and raises a fail flag.

The block advances one bit per `bit_en` pulse, so bit timing stays outside it. A host loads the fields, pulses `start`, and waits for `busy` to drop. It then reads `done`, `arb_lost` or `fail`.

Top module: `arb_frame_tx`

## Requirements
- R1: After reset `bus_tx` is recessive (1), and `busy`, `done`, `arb_lost`, `fail` and `err_cnt` are all 0.
- R2: A frame, including a retry, starts only after the transmitter has sampled 11 consecutive recessive bits on `bus_rx`. Its start bit is dominant (0) and appears on `bus_tx` in the bit period after the 11th recessive sample. While the bus stays dominant, no frame starts.
- R3: After the start bit the identifier is sent MSB first: bits 28..0 of `ident` when `ext_fmt`=1, bits 10..0 when `ext_fmt`=0.
- R4: After the identifier come the 4 bits of `len_code` (MSB first) and then min(`len_code`, 8) data bytes, sent from `payload[63]` downward. A length code above 8 is still sent as given but carries only 8 bytes.
- R5: If a sampled `bus_rx` differs from the identifier bit being driven, the transmitter releases the line (`bus_tx`=1) from the next bit on and sets `arb_lost`. It clears `busy` and drives nothing dominant until the next `start`.
- R6: Read-back mismatches outside the identifier, such as a data bit forced dominant, do not end the frame.
- R7: The acknowledge slot is driven recessive. If it reads back dominant, the 7 recessive end bits are sent, `done` is set and `busy` is cleared. At most one of `done`, `arb_lost`, `fail` is set.
- R8: If the acknowledge slot reads back recessive, `err_cnt` rises by exactly 1 after the end bits and the same frame is sent again.
- R9: `err_cnt` saturates at 255 and is cleared only by reset.
- R10: After 16 consecutive failed attempts, `fail` is set and `busy` is cleared. A new `start` clears `fail` and the attempt count.
- R11: In 11-bit mode `ident[10:7]` is the function code and `ident[6:0]` the node number. Bits 28..11 have no effect on the frame.
- R12: A `start` pulse while `busy` is high is ignored. It neither changes the frame in flight nor queues another one.
- R13: `bus_tx` changes only on a clock edge where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One pulse per bit period |
| start | input | 1 | Request to send; fields are latched when accepted |
| ext_fmt | input | 1 | 1 selects a 29-bit identifier, 0 an 11-bit one |
| ident | input | 29 | Identifier; 11-bit mode uses bits 10..0 |
| len_code | input | 4 | Length code; byte count is min(code, 8) |
| payload | input | 64 | Data; byte 0 is bits 63..56 |
| bus_rx | input | 1 | Level read back from the wired-AND line |
| bus_tx | output | 1 | Level driven onto the line (1 = released) |
| busy | output | 1 | A request is being served |
| done | output | 1 | Last request was acknowledged |
| arb_lost | output | 1 | Last request lost arbitration |
| fail | output | 1 | Last request gave up after 16 failed attempts |
| err_cnt | output | 8 | Saturating count of missed acknowledges |

## Verification
Each bit leaves `bus_tx` on the clock edge of one `bit_en` pulse. The bus is read back on the edge of the next pulse. The bench therefore samples `bus_tx` on the falling edge inside every `bit_en` cycle, and drives the competing node, the acknowledge and any forced bits at that same point, so they are settled for the edge that samples them. The start bit is expected one bit period after the 11th recessive sample, which makes the recessive run seen before it exactly 12 samples after a dominant stretch. `done`, `arb_lost` and `fail` are due on the edge that consumes the last end bit or the losing bit. `err_cnt` updates on the edge that consumes the last end bit. The bench reads these results only after `busy` has fallen.

// File: rtl/arb_tx_pkg.sv
package arb_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SOF,
        ST_ID,
        ST_LEN,
        ST_DATA,
        ST_ACK,
        ST_EOF
    } tx_state_e;

endpackage

// File: rtl/arb_idle_watch.sv
module arb_idle_watch #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bus_rx,
    output logic quiet
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (bit_en) begin
            if (!bus_rx)
                w_d.run = '0;
            else if (w_q.run != CNT_W'(IDLE_BITS))
                w_d.run = w_q.run + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign quiet = (w_q.run == CNT_W'(IDLE_BITS));

    // R2: a dominant sample always restarts the idle count
    p_dominant_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bus_rx) |=> !quiet);

endmodule

// File: rtl/arb_retry_track.sv
module arb_retry_track #(
    parameter int ERR_W     = 8,
    parameter int MAX_TRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             miss,
    output logic [ERR_W-1:0] err_cnt,
    output logic             last_try
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [TRY_W-1:0] tries;
    } retry_t;

    retry_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr)
            t_d.tries = '0;
        else if (miss && t_q.tries != TRY_W'(MAX_TRIES))
            t_d.tries = t_q.tries + TRY_W'(1);
        if (miss && t_q.err != {ERR_W{1'b1}})
            t_d.err = t_q.err + ERR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign err_cnt  = t_q.err;
    assign last_try = (t_q.tries == TRY_W'(MAX_TRIES - 1));

    // R9: once full the counter stays full
    p_err_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == {ERR_W{1'b1}}) |=> (err_cnt == {ERR_W{1'b1}}));

    // R8: the counter moves only on a missed acknowledge
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !miss |=> $stable(err_cnt));

endmodule

// File: rtl/arb_frame_tx.sv
module arb_frame_tx
    import arb_tx_pkg::*;
#(
    parameter int ID_EXT_W  = 29,
    parameter int ID_STD_W  = 11,
    parameter int LEN_W     = 4,
    parameter int MAX_BYTES = 8,
    parameter int IDLE_BITS = 11,
    parameter int EOF_BITS  = 7,
    parameter int MAX_TRIES = 16,
    parameter int ERR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  start,
    input  logic                  ext_fmt,
    input  logic [ID_EXT_W-1:0]   ident,
    input  logic [LEN_W-1:0]      len_code,
    input  logic [MAX_BYTES*8-1:0] payload,
    input  logic                  bus_rx,
    output logic                  bus_tx,
    output logic                  busy,
    output logic                  done,
    output logic                  arb_lost,
    output logic                  fail,
    output logic [ERR_W-1:0]      err_cnt
);
    localparam int DATA_W = MAX_BYTES * 8;
    localparam int IDX_W  = $clog2(((ID_EXT_W > DATA_W) ? ID_EXT_W : DATA_W) + 1);

    typedef struct packed {
        tx_state_e             st;
        logic [IDX_W-1:0]      idx;
        logic                  tx;
        logic                  ext;
        logic [ID_EXT_W-1:0]   id;
        logic [LEN_W-1:0]      len;
        logic [DATA_W-1:0]     data;
        logic                  ack_ok;
        logic                  done;
        logic                  lost;
        logic                  fail;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    logic             quiet;
    logic             clr_tries;
    logic             ack_miss;
    logic             last_try;
    logic [LEN_W-1:0] nbytes;
    logic [IDX_W-1:0] nbits;

    function automatic logic id_at(input logic [ID_EXT_W-1:0] v, input logic [IDX_W-1:0] k);
        logic [ID_EXT_W-1:0] s;
        s = v >> k;
        return s[0];
    endfunction

    function automatic logic len_at(input logic [LEN_W-1:0] v, input logic [IDX_W-1:0] k);
        logic [LEN_W-1:0] s;
        s = v >> k;
        return s[0];
    endfunction

    function automatic logic data_at(input logic [DATA_W-1:0] v, input logic [IDX_W-1:0] k);
        logic [DATA_W-1:0] s;
        s = v << k;
        return s[DATA_W-1];
    endfunction

    arb_idle_watch #(.IDLE_BITS(IDLE_BITS)) i_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .bus_rx (bus_rx),
        .quiet  (quiet)
    );

    arb_retry_track #(.ERR_W(ERR_W), .MAX_TRIES(MAX_TRIES)) i_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_tries),
        .miss     (ack_miss),
        .err_cnt  (err_cnt),
        .last_try (last_try)
    );

    always_comb begin
        r_d       = r_q;
        clr_tries = 1'b0;
        ack_miss  = 1'b0;
        nbytes    = (r_q.len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : r_q.len;
        nbits     = IDX_W'(nbytes) << 3;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_WAIT;
                    r_d.ext   = ext_fmt;
                    r_d.id    = ext_fmt ? ident
                              : {{(ID_EXT_W-ID_STD_W){1'b0}}, ident[ID_STD_W-1:0]};
                    r_d.len   = len_code;
                    r_d.data  = payload;
                    r_d.done  = 1'b0;
                    r_d.lost  = 1'b0;
                    r_d.fail  = 1'b0;
                    clr_tries = 1'b1;
                end
            end
            ST_WAIT: begin
                if (bit_en && quiet) begin
                    r_d.st = ST_SOF;
                    r_d.tx = 1'b0;
                end
            end
            ST_SOF: begin
                if (bit_en) begin
                    r_d.st  = ST_ID;
                    r_d.idx = r_q.ext ? IDX_W'(ID_EXT_W-1) : IDX_W'(ID_STD_W-1);
                    r_d.tx  = id_at(r_q.id, r_d.idx);
                end
            end
            ST_ID: begin
                if (bit_en) begin
                    if (bus_rx != r_q.tx) begin
                        r_d.st   = ST_IDLE;
                        r_d.tx   = 1'b1;
                        r_d.lost = 1'b1;
                    end else if (r_q.idx == '0) begin
                        r_d.st  = ST_LEN;
                        r_d.idx = IDX_W'(LEN_W-1);
                        r_d.tx  = len_at(r_q.len, r_d.idx);
                    end else begin
                        r_d.idx = r_q.idx - IDX_W'(1);
                        r_d.tx  = id_at(r_q.id, r_d.idx);
                    end
                end
            end
            ST_LEN: begin
                if (bit_en) begin
                    if (r_q.idx != '0) begin
                        r_d.idx = r_q.idx - IDX_W'(1);
                        r_d.tx  = len_at(r_q.len, r_d.idx);
                    end else if (nbits == '0) begin
                        r_d.st = ST_ACK;
                        r_d.tx = 1'b1;
                    end else begin
                        r_d.st  = ST_DATA;
                        r_d.idx = '0;
                        r_d.tx  = data_at(r_q.data, '0);
                    end
                end
            end
            ST_DATA: begin
                if (bit_en) begin
                    if (r_q.idx == nbits - IDX_W'(1)) begin
                        r_d.st = ST_ACK;
                        r_d.tx = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                        r_d.tx  = data_at(r_q.data, r_d.idx);
                    end
                end
            end
            ST_ACK: begin
                if (bit_en) begin
                    r_d.ack_ok = !bus_rx;
                    r_d.st     = ST_EOF;
                    r_d.idx    = '0;
                    r_d.tx     = 1'b1;
                end
            end
            ST_EOF: begin
                if (bit_en) begin
                    if (r_q.idx != IDX_W'(EOF_BITS-1)) begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end else if (r_q.ack_ok) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        clr_tries = 1'b1;
                    end else begin
                        ack_miss = 1'b1;
                        if (last_try) begin
                            r_d.st   = ST_IDLE;
                            r_d.fail = 1'b1;
                        end else begin
                            r_d.st = ST_WAIT;
                        end
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.tx <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_tx   = r_q.tx;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign arb_lost = r_q.lost;
    assign fail     = r_q.fail;

    // R13: the line only moves on a bit pulse
    p_hold_between_bits_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(bus_tx));

    // R5: a node that lost keeps the line released
    p_release_after_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (bus_tx && !busy));

    // R6: loss can only come out of the identifier phase
    p_loss_in_id_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> $past(r_q.st == ST_ID));

    // R7: outcomes are exclusive
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, arb_lost, fail}));

    // R10: giving up leaves the block idle
    p_fail_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !busy);

endmodule

// File: tb/test_arb_frame_tx.sv
module test_arb_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        start = 1'b0;
    logic        ext_fmt = 1'b0;
    logic [28:0] ident = '0;
    logic [3:0]  len_code = '0;
    logic [63:0] payload = '0;
    logic        bus_rx;
    logic        bus_tx, busy, done, arb_lost, fail;
    logic [7:0]  err_cnt;

    logic other_tx = 1'b1;
    logic ack_n    = 1'b1;
    logic jam_n    = 1'b1;
    logic hold_n   = 1'b1;

    assign bus_rx = bus_tx & other_tx & ack_n & jam_n & hold_n;

    always #10 clk = ~clk;

    arb_frame_tx i_arb_frame_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
        .ext_fmt(ext_fmt), .ident(ident), .len_code(len_code), .payload(payload),
        .bus_rx(bus_rx), .bus_tx(bus_tx), .busy(busy), .done(done),
        .arb_lost(arb_lost), .fail(fail), .err_cnt(err_cnt)
    );

    typedef struct {
        logic [127:0] bits;
        int           n;
        int           ack_pos;
        bit           ack;
        int           jam;
    } exp_t;

    exp_t q[$];

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    int  unexpected = 0;
    int  last_run = 0;
    int  mid_bad = 0;
    logic [28:0] comp_id = '0;
    int  comp_len = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic exp_t build(input bit ext, input logic [28:0] id, input logic [3:0] len,
                                   input logic [63:0] d, input bit ack);
        exp_t e;
        int p  = 1;
        int il = ext ? 29 : 11;
        int nb = (len > 4'd8) ? 8 : int'(len);
        e.bits    = '1;
        e.bits[0] = 1'b0;
        for (int i = il - 1; i >= 0; i--) begin e.bits[p] = id[i]; p++; end
        for (int i = 3; i >= 0; i--) begin e.bits[p] = len[i]; p++; end
        for (int i = 0; i < nb * 8; i++) begin e.bits[p] = d[63 - i]; p++; end
        e.ack_pos = p;
        e.n       = p + 1 + 7;
        e.ack     = ack;
        e.jam     = -1;
        return e;
    endfunction

    // Monitor: pops expected frames at each start bit and compares bit by bit.
    initial begin : monitor
        bit   in_frame = 0;
        bit   comp_live = 0;
        bit   mid_valid = 0;
        logic mid_val = 1'b1;
        int   pos = 0;
        int   bad_pos = -1;
        int   run = 0;
        exp_t cur;
        forever begin
            @(negedge clk);
            if (!bit_en) begin
                if (mid_valid && bus_tx !== mid_val) mid_bad++;
                mid_val   = bus_tx;
                mid_valid = 1;
            end else begin
                if (mid_valid && bus_tx !== mid_val) mid_bad++;
                mid_valid = 0;
                if (!in_frame && bus_tx === 1'b0) begin
                    last_run = run;
                    // R2: at least 11 recessive samples preceded the start bit
                    chk(run >= 12, "R2 idle run before start bit", 64'(run), 64'd12);
                    if (q.size() == 0) begin
                        unexpected++;
                        chk(0, "R12 frame with nothing expected", 64'd1, 64'd0);
                    end else begin
                        cur       = q.pop_front();
                        in_frame  = 1;
                        pos       = 0;
                        bad_pos   = -1;
                        comp_live = (comp_len > 0);
                    end
                end
                if (in_frame) begin
                    if (bus_tx !== cur.bits[pos] && bad_pos < 0) bad_pos = pos;
                    other_tx = 1'b1;
                    if (comp_live && pos >= 1 && pos <= comp_len) begin
                        other_tx = comp_id[comp_len - pos];
                        if (other_tx != cur.bits[pos]) comp_live = 0;
                    end
                    ack_n = !(cur.ack && pos == cur.ack_pos);
                    jam_n = !(pos == cur.jam);
                    pos++;
                    if (pos == cur.n) begin
                        in_frame = 0;
                        // R3 R4: frame content and order
                        chk(bad_pos < 0, "R3/R4 frame bit mismatch at position",
                            64'(bad_pos), 64'hFFFF_FFFF_FFFF_FFFF);
                    end
                end else begin
                    other_tx = 1'b1;
                    ack_n    = 1'b1;
                    jam_n    = 1'b1;
                end
                #1;
                if (bus_rx) run++;
                else        run = 0;
            end
        end
    end

    initial begin : bit_gen
        forever begin
            repeat (3) @(posedge clk);
            #2 bit_en = 1'b1;
            @(posedge clk);
            #2 bit_en = 1'b0;
        end
    end

    task automatic send(input bit ext, input logic [28:0] id, input logic [3:0] len,
                        input logic [63:0] d);
        @(posedge clk);
        #2;
        ext_fmt = ext; ident = id; len_code = len; payload = d; start = 1'b1;
        @(posedge clk);
        #2 start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic wait_bits(input int n);
        repeat (n * 4) @(posedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin : main
        exp_t e;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bus_tx === 1'b1, "R1 bus_tx after reset", 64'(bus_tx), 64'd1);
        chk({busy, done, arb_lost, fail} === 4'b0, "R1 flags after reset",
            64'({busy, done, arb_lost, fail}), 64'd0);
        chk(err_cnt === 8'd0, "R1 err_cnt after reset", 64'(err_cnt), 64'd0);

        // R11 R12: 11-bit id with junk above bit 10, second start mid-frame
        q.push_back(build(0, 29'h0000_0535, 4'd2, 64'hC3A5_0000_0000_0000, 1));
        send(0, {18'h2B3C1, 4'hA, 7'h35}, 4'd2, 64'hC3A5_0000_0000_0000);
        wait_bits(10);
        @(posedge clk);
        #2 start = 1'b1; ident = 29'h1234_5678; len_code = 4'd5; ext_fmt = 1'b1;
        @(posedge clk);
        #2 start = 1'b0;
        wait_idle();
        chk(done === 1'b1, "R7 done after acknowledged frame", 64'(done), 64'd1);
        wait_bits(60);
        chk(q.size() == 0 && unexpected == 0 && !busy, "R12 start while busy ignored",
            64'(unexpected), 64'd0);

        // R3: 29-bit identifier, full payload
        q.push_back(build(1, 29'h1A5F_0C3E, 4'd8, 64'h0123_4567_89AB_CDEF, 1));
        send(1, 29'h1A5F_0C3E, 4'd8, 64'h0123_4567_89AB_CDEF);
        wait_idle();
        chk(done === 1'b1, "R3 done after 29-bit frame", 64'(done), 64'd1);

        // R4: length code above 8 clamps the payload
        q.push_back(build(0, 29'h0000_02F1, 4'd13, 64'hF0E1_D2C3_B4A5_9687, 1));
        send(0, 29'h0000_02F1, 4'd13, 64'hF0E1_D2C3_B4A5_9687);
        wait_idle();
        chk(done === 1'b1, "R4 done after clamped length", 64'(done), 64'd1);

        // R4: zero-length frame
        q.push_back(build(0, 29'h0000_0001, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1));
        send(0, 29'h0000_0001, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_idle();
        chk(done === 1'b1, "R4 done after empty frame", 64'(done), 64'd1);

        // R5: competitor with lower id wins on the last identifier bit
        comp_id = 29'h0000_0454; comp_len = 11;
        e = build(0, 29'h0000_0455, 4'd1, 64'h5500_0000_0000_0000, 1);
        e.n = 12;
        q.push_back(e);
        send(0, 29'h0000_0455, 4'd1, 64'h5500_0000_0000_0000);
        wait_idle();
        chk(arb_lost === 1'b1 && done === 1'b0, "R5 arbitration lost flag",
            64'({arb_lost, done}), 64'b10);
        wait_bits(30);
        chk(bus_tx === 1'b1 && unexpected == 0 && q.size() == 0, "R5 line stays released",
            64'(bus_tx), 64'd1);

        // R5: competitor with higher id loses, we complete
        comp_id = 29'h0000_0200; comp_len = 11;
        q.push_back(build(0, 29'h0000_0123, 4'd1, 64'hA700_0000_0000_0000, 1));
        send(0, 29'h0000_0123, 4'd1, 64'hA700_0000_0000_0000);
        wait_idle();
        chk(done === 1'b1 && arb_lost === 1'b0, "R5 lower id wins", 64'({done, arb_lost}), 64'b10);
        comp_len = 0;

        // R6: a forced dominant data bit does not stop the frame
        e = build(0, 29'h0000_07F0, 4'd1, 64'hFF00_0000_0000_0000, 1);
        e.jam = 16;
        q.push_back(e);
        send(0, 29'h0000_07F0, 4'd1, 64'hFF00_0000_0000_0000);
        wait_idle();
        chk(done === 1'b1 && arb_lost === 1'b0, "R6 data mismatch ignored",
            64'({done, arb_lost}), 64'b10);

        // R8: two missed acknowledges then success
        q.push_back(build(0, 29'h0000_0333, 4'd1, 64'h3C00_0000_0000_0000, 0));
        q.push_back(build(0, 29'h0000_0333, 4'd1, 64'h3C00_0000_0000_0000, 0));
        q.push_back(build(0, 29'h0000_0333, 4'd1, 64'h3C00_0000_0000_0000, 1));
        send(0, 29'h0000_0333, 4'd1, 64'h3C00_0000_0000_0000);
        wait_idle();
        chk(done === 1'b1 && q.size() == 0, "R8 resent until acknowledged", 64'(q.size()), 64'd0);
        chk(err_cnt === 8'd2, "R8 err_cnt after two misses", 64'(err_cnt), 64'd2);

        // R2: dominant bus holds off the start, exact gap after release
        hold_n = 1'b0;
        q.push_back(build(0, 29'h0000_0111, 4'd0, 64'd0, 1));
        send(0, 29'h0000_0111, 4'd0, 64'd0);
        wait_bits(30);
        chk(q.size() == 1 && bus_tx === 1'b1, "R2 no start while bus dominant", 64'(q.size()), 64'd1);
        @(posedge clk);
        #2 hold_n = 1'b1;
        wait_idle();
        chk(last_run == 12, "R2 start bit one period after 11 recessive samples",
            64'(last_run), 64'd12);

        // R10: give up after 16 failed attempts
        for (int i = 0; i < 16; i++) q.push_back(build(0, 29'h0000_0042, 4'd0, 64'd0, 0));
        send(0, 29'h0000_0042, 4'd0, 64'd0);
        wait_idle();
        chk(fail === 1'b1 && done === 1'b0 && q.size() == 0, "R10 fail after 16 attempts",
            64'({fail, done}), 64'b10);
        chk(err_cnt === 8'd18, "R10 err_cnt after give-up", 64'(err_cnt), 64'd18);
        wait_bits(30);
        chk(unexpected == 0, "R10 no further attempt", 64'(unexpected), 64'd0);
        q.push_back(build(0, 29'h0000_0042, 4'd0, 64'd0, 1));
        send(0, 29'h0000_0042, 4'd0, 64'd0);
        wait_idle();
        chk(done === 1'b1 && fail === 1'b0, "R10 new start clears fail", 64'({done, fail}), 64'b10);

        // R9: drive the counter past 255
        for (int k = 0; k < 15; k++) begin
            for (int i = 0; i < 16; i++) q.push_back(build(0, 29'h0000_0010, 4'd0, 64'd0, 0));
            send(0, 29'h0000_0010, 4'd0, 64'd0);
            wait_idle();
            chk(fail === 1'b1 && q.size() == 0, "R10 full attempt run each request",
                64'(q.size()), 64'd0);
        end
        chk(err_cnt === 8'd255, "R9 err_cnt saturates", 64'(err_cnt), 64'd255);

        // R13: line held steady between bit pulses
        chk(mid_bad == 0, "R13 bus_tx changed between bit pulses", 64'(mid_bad), 64'd0);
        chk(unexpected == 0, "R12 no unexpected frames overall", 64'(unexpected), 64'd0);

        summary();
    end

endmodule